// File: doc/BRIEF.md
# Strip-Mining Vector Loop Sequencer

This block is the control engine of a chunked array loop. Software hands it an element count, the largest chunk the vector datapath can take in one pass, the element size and a set of base addresses: one for each source array and one for the destination array. The engine then walks the arrays chunk by chunk. Each chunk is as long as the smaller of the elements still outstanding and the largest chunk allowed. For each chunk it issues one read descriptor per source stream and then one write descriptor for the result. After the write it shrinks the outstanding count and moves every stream's address past the chunk.

Each descriptor is held on the request port until the memory side acknowledges it with a one-cycle `req_done`. The engine then moves on to the next descriptor. When the outstanding count reaches zero the engine raises a one-cycle `done` and returns to idle. The arithmetic on the data and the memory itself sit outside the block.

Top module: `stripmine_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `req_valid` and `done` are all 0.
- R2: Every descriptor of a chunk carries `req_len` = min(outstanding count, `vlmax`). A `vlmax` of 0 is treated as 1.
- R3: After each chunk the outstanding count drops by exactly that chunk's length. A job of n elements therefore takes ceil(n / vlmax) chunks, and when n is not a multiple of vlmax the last chunk is n mod vlmax long.
- R4: Within a chunk the descriptors come in a fixed order. First come reads (`req_write` = 0) with `req_src_idx` counting up from 0 to NUM_SRC-1. Last comes one write (`req_write` = 1, `req_src_idx` = 0).
- R5: Each stream's address starts at its base. After each chunk, every stream's address grows by (chunk length << `elem_log2`), where `elem_log2` codes 0, 1, 2 and 3 mean 1-, 2-, 4- and 8-byte elements. All streams move together, and addresses wrap modulo 2^ADDR_W.
- R6: A descriptor stays valid and unchanged until `req_done` is seen with it. A `req_done` while `req_valid` is 0 changes nothing.
- R7: A `start` with `n_elems` = 0 raises `done` for one cycle, one clock after `start` is sampled, and issues no descriptor.
- R8: After the final write is acknowledged, `done` is 0 for one cycle and then 1 for exactly one cycle. `busy` is 0 on the following cycle.
- R9: A `start` while `busy` is 1 is ignored. The running job goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job (sampled only when idle) |
| n_elems | input | CNT_W | Element count of the job |
| elem_log2 | input | 2 | log2 of the element size in bytes |
| vlmax | input | CNT_W | Largest chunk length (0 acts as 1) |
| src_base | input | NUM_SRC*ADDR_W | Source base addresses, stream 0 in the low bits |
| dst_base | input | ADDR_W | Destination base address |
| req_done | input | 1 | Acknowledge of the current descriptor |
| busy | output | 1 | A job is in progress |
| req_valid | output | 1 | A descriptor is presented |
| req_write | output | 1 | 1 for the destination write, 0 for a source read |
| req_src_idx | output | SRC_IDX_W | Source stream index of a read |
| req_addr | output | ADDR_W | Start address of the chunk |
| req_len | output | CNT_W | Chunk length in elements |
| done | output | 1 | One-cycle job completion pulse |

## Verification
The first read of a job is presented two clocks after `start` is sampled. A read that follows an acknowledged read appears on the very next clock. The first read of the next chunk comes three clocks after the write is acknowledged. `done` comes one clock after a zero-length start, or two clocks after the last write's acknowledge. The bench samples at falling edges. It walks a reference model of the chunk sequence, waiting for each expected descriptor and checking every field the moment it appears. It pins the `done` timing to the exact falling edge these latencies give, and it randomises acknowledge delays so that descriptor holding is checked on every waiting cycle.

// File: rtl/stripmine_pkg.sv
// Shared types of the strip-mining sequencer.
package stripmine_pkg;

    // Control states of the chunk loop.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONFIG,
        ST_READ_A,
        ST_READ_B,
        ST_WRITE,
        ST_ADVANCE,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/stripmine_chunk.sv
// Chunk length unit: returns min(remaining, limit) with a limit of 0 taken as 1.
// Assumes: purely combinational, used while the sequencer sets up a chunk.
module stripmine_chunk #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] remaining,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] chunk_len
);

    logic [CNT_W-1:0] eff_limit;

    // Clamp the limit to at least one element, then take the minimum.
    always_comb begin
        eff_limit = (limit == '0) ? CNT_W'(1) : limit;
        chunk_len = (remaining < eff_limit) ? remaining : eff_limit;
    end

endmodule

// File: rtl/stripmine_ptr.sv
// One address stream: loads its base at job start, steps by len << log2 on advance.
// Assumes: load and advance are never high together.
module stripmine_ptr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic [CNT_W-1:0]  chunk_len,
    input  logic [1:0]        elem_log2,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] step;

    // Byte distance of one chunk.
    always_comb step = ADDR_W'(chunk_len) << elem_log2;

    // Address register: base on load, bumped on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (load)    ptr <= base;
        else if (advance) ptr <= ptr + step;
    end

    // R5: the address only moves on a load or an advance.
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(ptr));

endmodule

// File: rtl/stripmine_seq.sv
// Strip-mining loop sequencer. It walks NUM_SRC source streams and one destination
// stream in chunks of min(remaining, vlmax). For each chunk it issues the reads in
// stream order, then the write, then advances every stream at once.
// Assumes: req_done is a one-cycle acknowledge, seen only while req_valid is 1.
module stripmine_seq
    import stripmine_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int NUM_SRC   = 2,
    localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [CNT_W-1:0]          n_elems,
    input  logic [1:0]                elem_log2,
    input  logic [CNT_W-1:0]          vlmax,
    input  logic [NUM_SRC*ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0]         dst_base,
    input  logic                      req_done,
    output logic                      busy,
    output logic                      req_valid,
    output logic                      req_write,
    output logic [SRC_IDX_W-1:0]      req_src_idx,
    output logic [ADDR_W-1:0]         req_addr,
    output logic [CNT_W-1:0]          req_len,
    output logic                      done
);

    localparam int NUM_STREAMS = NUM_SRC + 1;

    seq_state_t           state_q, state_d;
    logic [CNT_W-1:0]     rem_q;
    logic [CNT_W-1:0]     vlmax_q;
    logic [1:0]           log2_q;
    logic [CNT_W-1:0]     vl_q;
    logic [CNT_W-1:0]     vl_calc;
    logic [SRC_IDX_W-1:0] src_sel_q;
    logic                 accept;
    logic                 load_ptrs;
    logic                 adv_ptrs;
    logic [ADDR_W-1:0]    ptr_q [NUM_STREAMS];

    stripmine_chunk #(.CNT_W(CNT_W)) u_chunk (
        .remaining (rem_q),
        .limit     (vlmax_q),
        .chunk_len (vl_calc)
    );

    // One address stream per source plus the destination (last index).
    for (genvar gi = 0; gi < NUM_STREAMS; gi++) begin : g_stream
        logic [ADDR_W-1:0] base_sel;
        if (gi < NUM_SRC) begin : g_src
            assign base_sel = src_base[gi*ADDR_W +: ADDR_W];
        end else begin : g_dst
            assign base_sel = dst_base;
        end
        stripmine_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_ptrs),
            .base      (base_sel),
            .advance   (adv_ptrs),
            .chunk_len (vl_q),
            .elem_log2 (log2_q),
            .ptr       (ptr_q[gi])
        );
    end

    // Request port decode from the current state.
    always_comb begin
        req_valid   = (state_q == ST_READ_A) || (state_q == ST_READ_B) || (state_q == ST_WRITE);
        req_write   = (state_q == ST_WRITE);
        req_src_idx = req_write ? '0 : src_sel_q;
        req_addr    = req_write ? ptr_q[NUM_SRC] : ptr_q[src_sel_q];
        req_len     = vl_q;
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        accept      = req_valid && req_done;
        load_ptrs   = (state_q == ST_IDLE) && start;
        adv_ptrs    = (state_q == ST_ADVANCE);
    end

    // Next-state logic of the chunk loop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = (n_elems == '0) ? ST_DONE : ST_CONFIG;
            ST_CONFIG:  state_d = ST_READ_A;
            ST_READ_A:  if (accept) state_d = (NUM_SRC > 1) ? ST_READ_B : ST_WRITE;
            ST_READ_B:  if (accept && src_sel_q == SRC_IDX_W'(NUM_SRC - 1)) state_d = ST_WRITE;
            ST_WRITE:   if (accept) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = (rem_q == vl_q) ? ST_DONE : ST_CONFIG;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State, job parameters, chunk length and source selector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            vlmax_q   <= '0;
            log2_q    <= '0;
            vl_q      <= '0;
            src_sel_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_ptrs) begin
                rem_q   <= n_elems;
                vlmax_q <= vlmax;
                log2_q  <= elem_log2;
            end
            if (state_q == ST_CONFIG) begin
                vl_q      <= vl_calc;
                src_sel_q <= '0;
            end
            if ((state_q == ST_READ_A || state_q == ST_READ_B) && accept
                && src_sel_q != SRC_IDX_W'(NUM_SRC - 1))
                src_sel_q <= src_sel_q + SRC_IDX_W'(1);
            if (adv_ptrs) rem_q <= rem_q - vl_q;
        end
    end

    // R2: a descriptor never exceeds the clamped limit nor what is left, and is never empty.
    a_r2_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0 && req_len <= rem_q
                       && req_len <= ((vlmax_q == '0) ? CNT_W'(1) : vlmax_q)));

    // R6: an unacknowledged descriptor is held unchanged.
    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_done) |=> (req_valid && $stable(req_addr)
                                      && $stable(req_write) && $stable(req_src_idx)));

    // R3: each advance takes exactly one chunk off the outstanding count.
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADVANCE) |=> (rem_q == $past(rem_q) - $past(vl_q)));

    // R8: completion is a single-cycle pulse and leaves nothing outstanding.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(state_q) == ST_ADVANCE) |-> (rem_q == '0));

endmodule

// File: tb/stripmine_seq_bench.sv
// Self-checking bench: directed corners plus seeded random jobs against a reference loop.
module stripmine_seq_bench;

    localparam int ADDR_W  = 32;
    localparam int CNT_W   = 16;
    localparam int NUM_SRC = 2;
    localparam int IDX_W   = 1;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      start = 1'b0;
    logic [CNT_W-1:0]          n_elems = '0;
    logic [1:0]                elem_log2 = '0;
    logic [CNT_W-1:0]          vlmax = '0;
    logic [NUM_SRC*ADDR_W-1:0] src_base = '0;
    logic [ADDR_W-1:0]         dst_base = '0;
    logic                      req_done = 1'b0;
    logic                      busy, req_valid, req_write, done;
    logic [IDX_W-1:0]          req_src_idx;
    logic [ADDR_W-1:0]         req_addr;
    logic [CNT_W-1:0]          req_len;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    stripmine_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_stripmine_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems),
        .elem_log2(elem_log2), .vlmax(vlmax), .src_base(src_base),
        .dst_base(dst_base), .req_done(req_done), .busy(busy),
        .req_valid(req_valid), .req_write(req_write), .req_src_idx(req_src_idx),
        .req_addr(req_addr), .req_len(req_len), .done(done)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int ref_len(input int rem, input int lim);
        int l = (lim == 0) ? 1 : lim;
        return (rem < l) ? rem : l;
    endfunction

    // Wait for a descriptor, check it, hold it for a random time, then acknowledge.
    task automatic expect_req(input bit wr, input int idx, input logic [ADDR_W-1:0] addr,
                              input int len, input int max_dly, input bit mid_start);
        int guard = 0;
        int dly;
        while (!req_valid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk(req_valid, "R6 descriptor appears", req_valid, 1);
        chk(req_write == wr, "R4 read/write order", req_write, wr);
        chk(int'(req_src_idx) == (wr ? 0 : idx), "R4 stream index", req_src_idx, wr ? 0 : idx);
        chk(req_addr == addr, "R5 chunk address", req_addr, addr);
        chk(int'(req_len) == len, "R2 chunk length", req_len, len);
        dly = $urandom_range(max_dly, 0);
        for (int d = 0; d < dly; d++) begin
            if (mid_start && d == 0) begin
                start = 1'b1;
                n_elems = CNT_W'(1);
            end
            @(negedge clk);
            start = 1'b0;
            chk(req_valid && req_addr == addr && req_write == wr,
                "R6 R9 descriptor held", req_addr, addr);
        end
        req_done = 1'b1;
        @(negedge clk);
        req_done = 1'b0;
    endtask

    // Run one job and compare every descriptor and the completion timing.
    task automatic run_job(input int n, input int lim, input int lg,
                           input logic [ADDR_W-1:0] b0, input logic [ADDR_W-1:0] b1,
                           input logic [ADDR_W-1:0] bd, input int max_dly, input bit mid_start);
        int rem = n;
        int len;
        logic [ADDR_W-1:0] off = '0;
        n_elems   = CNT_W'(n);
        vlmax     = CNT_W'(lim);
        elem_log2 = 2'(lg);
        src_base  = {b1, b0};
        dst_base  = bd;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R7 zero-length done", done, 1);
            chk(req_valid == 1'b0, "R7 no descriptor", req_valid, 0);
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R7 pulse ends", done, 0);
            return;
        end
        chk(req_valid == 1'b0 && busy == 1'b1, "R2 setup cycle", req_valid, 0);
        while (rem > 0) begin
            len = ref_len(rem, lim);
            expect_req(1'b0, 0, b0 + off, len, max_dly, mid_start);
            mid_start = 1'b0;
            expect_req(1'b0, 1, b1 + off, len, max_dly, 1'b0);
            expect_req(1'b1, 0, bd + off, len, max_dly, 1'b0);
            rem -= len;
            off += ADDR_W'(len) << lg;
        end
        chk(done == 1'b0, "R8 advance cycle", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R3 R8 done after last chunk", done, 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 single pulse", done, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(busy == 0 && req_valid == 0 && done == 0, "R1 reset state", {busy, req_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && req_valid == 0 && done == 0, "R1 idle after reset", {busy, req_valid, done}, 0);

        // R6: an acknowledge while idle changes nothing.
        req_done = 1'b1;
        @(negedge clk);
        req_done = 1'b0;
        @(negedge clk);
        chk(busy == 0 && req_valid == 0 && done == 0, "R6 stray acknowledge", busy, 0);

        run_job(10, 4, 2, 32'h1000, 32'h2000, 32'h3000, 2, 1'b0);   // R3 short tail of 2
        run_job(8, 4, 0, 32'h0100, 32'h0200, 32'h0300, 0, 1'b0);    // R3 exact multiple
        run_job(3, 8, 3, 32'h4000, 32'h5000, 32'h6000, 1, 1'b0);    // R2 single short chunk
        run_job(5, 0, 1, 32'h0010, 32'h0020, 32'h0030, 1, 1'b0);    // R2 limit 0 acts as 1
        run_job(0, 4, 2, 32'h0, 32'h0, 32'h0, 0, 1'b0);             // R7 empty job
        run_job(7, 3, 2, 32'hFFFF_FFF0, 32'h10, 32'h20, 3, 1'b1);   // R9 start while busy, R5 wrap
        for (int j = 0; j < 16; j++) begin
            run_job($urandom_range(40, 0), $urandom_range(9, 0), $urandom_range(3, 0),
                    $urandom(), $urandom(), $urandom(), 3, 1'b0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule